// File: doc/BRIEF.md
# Streaming Integer Matrix Product Engine

This block multiplies two signed integer matrices, X of size n×m and Y of size m×p, while they stream through it. The host lays out the operands so that every output element is preceded by the m elements of one row of X, sent on the left stream, and the m elements of the matching column of Y, sent on the right stream, element for element. The engine multiplies one left/right pair per clock, sums m products, emits the sum as one element of the product, and clears its running sum. Results leave in row-major order: row 0 columns 0..p-1, then row 1, and so on.

The matrix dimensions travel in-band. Each job opens with three header words on the left stream. The right stream carries only data. When the last result of a job has been taken, the engine pulses `done` for one cycle and waits for the next header. All three streams use a valid/ready handshake. A stalled output holds both inputs, so no product is lost.

Top module: `stream_matmul_engine`

## Requirements
- R1: After reset, and after every finished job, the first three words accepted on the left stream are a header giving the row count n, then the column count p, then the inner length m, each as a 32-bit unsigned value. The right stream is never accepted while a header is being read (`rhs_ready` stays low).
- R2: While a job computes, a word is accepted on the right stream only in a cycle in which a word is also accepted on the left stream, so exactly one operand pair is consumed per accepted cycle.
- R3: Each result equals the sum of m products of signed 32-bit operands, reduced modulo 2^32 (two's-complement wrap). Result k (counting from 0) is element (k/p, k mod p) of the product.
- R4: The running sum starts from zero for every result, so no earlier result leaks into the next one.
- R5: A job with non-zero n, p and m produces exactly n·p results and no more.
- R6: While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` hold their values and neither input stream is accepted.
- R7: `done` is high for exactly one cycle, the cycle after the handshake of the last result, and `res_valid` is low while `done` is high.
- R8: If any of n, p or m is zero, the job produces no result, and `done` pulses in the cycle after the third header word is accepted.
- R9: While and after reset is held, `res_valid`, `done` and `rhs_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lhs_valid | input | 1 | Left stream word valid |
| lhs_ready | output | 1 | Left stream word accepted when high with valid |
| lhs_data | input | 32 | Header word or row element of X |
| rhs_valid | input | 1 | Right stream word valid |
| rhs_ready | output | 1 | Right stream word accepted when high with valid |
| rhs_data | input | 32 | Column element of Y |
| res_valid | output | 1 | Result word valid |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | 32 | Product element, signed, wrapped to 32 bits |
| done | output | 1 | One-cycle pulse when a job is finished |

## Verification
Two things can happen in the same cycle here: the closing product of one output element fills the output register while the previous result is still being handed off, and with random backpressure an operand pair can arrive just as downstream refuses the pending result. The bench sweeps every shape with n, p and m from 0 to 4, first with all streams at full rate and then with random gaps on both inputs and random `res_ready`. This puts result handoff, refill and stall into adjacent and overlapping cycles. Every result is compared with a product worked out in the bench from random full-range operands. The bench also checks that neither input moves and the result holds while a stall lasts, and that `done` falls in the one cycle the requirements fix.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [1:0] {
    PH_HEADER = 2'd0,
    PH_COMPUTE = 2'd1,
    PH_FLUSH  = 2'd2
  } smm_phase_t;
endpackage

// File: rtl/smm_header.sv
module smm_header #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] rows_o,
  output logic [W-1:0] cols_o,
  output logic         last_o
);
  localparam int HDR_WORDS = 3;
  localparam int IW = $clog2(HDR_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(HDR_WORDS - 1);

  logic [IW-1:0] idx_q;
  logic          take;

  assign take   = en_i && valid_i;
  assign last_o = take && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      rows_o <= '0;
      cols_o <= '0;
    end else if (take) begin
      if (idx_q == '0)       rows_o <= data_i;
      if (idx_q == IW'(1))   cols_o <= data_i;
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IW'(1);
    end
  end

  // R1: the word counter never leaves the header range
  a_r1_idx_range: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST_IDX) else $error("header index out of range");
endmodule

// File: rtl/smm_iter.sv
module smm_iter #(
  parameter int W  = 32,
  parameter int CW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [W-1:0]  inner_i,
  input  logic [CW-1:0] total_i,
  input  logic          step_i,
  output logic          last_k_o,
  output logic          last_out_o
);
  logic [W-1:0]  inner_q;
  logic [W-1:0]  k_q;
  logic [CW-1:0] total_q;
  logic [CW-1:0] out_q;

  assign last_k_o   = (k_q == inner_q - W'(1));
  assign last_out_o = last_k_o && (out_q == total_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      inner_q <= '0;
      k_q     <= '0;
      total_q <= '0;
      out_q   <= '0;
    end else if (load_i) begin
      inner_q <= inner_i;
      total_q <= total_i;
      k_q     <= '0;
      out_q   <= '0;
    end else if (step_i) begin
      if (last_k_o) begin
        k_q   <= '0;
        out_q <= out_q + CW'(1);
      end else begin
        k_q <= k_q + W'(1);
      end
    end
  end

  // R4: the inner index stays below the inner length whenever a pair is taken
  a_r4_k_range: assert property (@(posedge clk) disable iff (rst)
    step_i |-> (k_q < inner_q)) else $error("inner index overrun");
  // R5: no result index beyond the job's result count
  a_r5_out_range: assert property (@(posedge clk) disable iff (rst)
    step_i |-> (out_q < total_q)) else $error("result count overrun");
endmodule

// File: rtl/smm_mac.sv
module smm_mac #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire_i,
  input  logic         clear_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] acc_q;
  logic [W-1:0] prod;

  // low W bits of the product are the same for signed and unsigned operands
  assign prod  = x_i * y_i;
  assign sum_o = acc_q + prod;

  always_ff @(posedge clk) begin
    if (rst)         acc_q <= '0;
    else if (fire_i) acc_q <= clear_i ? '0 : sum_o;
  end

  // R4: the running sum is empty after each closing product
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    (fire_i && clear_i) |=> (acc_q == '0)) else $error("sum not cleared");
endmodule

// File: rtl/stream_matmul_engine.sv
module stream_matmul_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lhs_valid,
  output logic         lhs_ready,
  input  logic [W-1:0] lhs_data,
  input  logic         rhs_valid,
  output logic         rhs_ready,
  input  logic [W-1:0] rhs_data,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data,
  output logic         done
);
  import smm_pkg::*;
  localparam int CW = 2 * W;

  smm_phase_t    phase_q;
  logic          in_hdr, in_run, slot_free, fire;
  logic          hdr_last, last_k, last_out, empty_job;
  logic [W-1:0]  rows, cols, sum;
  logic [CW-1:0] total;

  assign in_hdr    = (phase_q == PH_HEADER);
  assign in_run    = (phase_q == PH_COMPUTE);
  assign slot_free = !res_valid || res_ready;
  assign lhs_ready = in_hdr || (in_run && slot_free && rhs_valid);
  assign rhs_ready = in_run && slot_free && lhs_valid;
  assign fire      = in_run && slot_free && lhs_valid && rhs_valid;
  assign total     = {{W{1'b0}}, rows} * {{W{1'b0}}, cols};
  assign empty_job = (lhs_data == '0) || (rows == '0) || (cols == '0);

  smm_header #(.W(W)) u_hdr (
    .clk(clk), .rst(rst), .en_i(in_hdr), .valid_i(lhs_valid),
    .data_i(lhs_data), .rows_o(rows), .cols_o(cols), .last_o(hdr_last)
  );

  smm_iter #(.W(W), .CW(CW)) u_iter (
    .clk(clk), .rst(rst), .load_i(hdr_last), .inner_i(lhs_data),
    .total_i(total), .step_i(fire), .last_k_o(last_k), .last_out_o(last_out)
  );

  smm_mac #(.W(W)) u_mac (
    .clk(clk), .rst(rst), .fire_i(fire), .clear_i(last_k),
    .x_i(lhs_data), .y_i(rhs_data), .sum_o(sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_HEADER;
      res_valid <= 1'b0;
      res_data  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fire && last_k) begin
        res_valid <= 1'b1;
        res_data  <= sum;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
      case (phase_q)
        PH_HEADER: if (hdr_last) begin
          if (empty_job) done <= 1'b1;
          else           phase_q <= PH_COMPUTE;
        end
        PH_COMPUTE: if (fire && last_out) phase_q <= PH_FLUSH;
        PH_FLUSH: if (res_valid && res_ready) begin
          phase_q <= PH_HEADER;
          done    <= 1'b1;
        end
        default: phase_q <= PH_HEADER;
      endcase
    end
  end

  // R2: right-stream acceptance only alongside left-stream acceptance
  a_r2_lockstep: assert property (@(posedge clk) disable iff (rst)
    (rhs_valid && rhs_ready) |-> (lhs_valid && lhs_ready)) else $error("pair split");
  // R6: a refused result is held
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))) else $error("result dropped");
  // R6: a refused result blocks both inputs
  a_r6_stall: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |-> (!rhs_ready && !(lhs_ready && in_run))) else $error("input taken in stall");
  // R7: done is a single-cycle pulse
  a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done too long");
  // R7: no result pending while done is high
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !res_valid) else $error("result with done");
  // R1: right stream idle during header
  a_r1_no_rhs_hdr: assert property (@(posedge clk) disable iff (rst)
    in_hdr |-> !rhs_ready) else $error("rhs taken in header");
endmodule

// File: tb/tb_stream_matmul_engine.sv
module tb_stream_matmul_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lhs_valid = 1'b0, rhs_valid = 1'b0, res_ready = 1'b0;
  logic [31:0] lhs_data = '0, rhs_data = '0;
  logic        lhs_ready, rhs_ready, res_valid, done;
  logic [31:0] res_data;

  stream_matmul_engine #(.W(32)) dut (
    .clk(clk), .rst(rst), .lhs_valid(lhs_valid), .lhs_ready(lhs_ready),
    .lhs_data(lhs_data), .rhs_valid(rhs_valid), .rhs_ready(rhs_ready),
    .rhs_data(rhs_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .done(done)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int n_c, p_c, m_c, mode;
  bit lhs_fin;
  logic [31:0] mx [5][5];
  logic [31:0] my [5][5];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_at(input int idx);
    logic [31:0] s = '0;
    for (int k = 0; k < m_c; k++) s = s + mx[idx / p_c][k] * my[k][idx % p_c];
    return s;
  endfunction

  task automatic drive_lhs();
    int total = 3 + n_c * p_c * m_c;
    for (int w = 0; w < total; w++) begin
      logic [31:0] word;
      bit taken = 0;
      if (w == 0) word = n_c;
      else if (w == 1) word = p_c;
      else if (w == 2) word = m_c;
      else word = mx[(w - 3) / (p_c * m_c)][(w - 3) % m_c];
      while (!taken) begin
        @(negedge clk);
        if (mode == 1 && $urandom_range(0, 3) == 0) lhs_valid = 1'b0;
        else begin lhs_valid = 1'b1; lhs_data = word; end
        #5;
        taken = lhs_valid && lhs_ready;
        if (taken && w < 3) chk(rhs_ready == 1'b0, "R1 rhs_ready in header", 32'(rhs_ready), 0);
        @(posedge clk);
      end
    end
    lhs_fin = 1'b1;
    @(negedge clk);
    lhs_valid = 1'b0;
  endtask

  task automatic drive_rhs();
    int total = n_c * p_c * m_c;
    for (int t = 0; t < total; t++) begin
      bit taken = 0;
      while (!taken) begin
        @(negedge clk);
        if (mode == 1 && $urandom_range(0, 3) == 0) rhs_valid = 1'b0;
        else begin rhs_valid = 1'b1; rhs_data = my[t % m_c][(t / m_c) % p_c]; end
        #5;
        taken = rhs_valid && rhs_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    rhs_valid = 1'b0;
  endtask

  task automatic receive();
    int expn = n_c * p_c * m_c == 0 ? 0 : n_c * p_c;
    int got = 0;
    bit prev_final = 0, fin_seen = 0, stalled = 0, exp_done;
    logic [31:0] held = '0;
    forever begin
      @(negedge clk);
      res_ready = (mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
      #5;
      exp_done = (expn > 0) ? prev_final : (lhs_fin && !fin_seen);
      fin_seen = lhs_fin;
      prev_final = 0;
      if (stalled) chk(res_valid && res_data == held, "R6 held result", res_data, held);
      stalled = 0;
      if (res_valid && !res_ready) begin
        chk(!lhs_ready && !rhs_ready, "R6 inputs blocked", {30'b0, lhs_ready, rhs_ready}, 0);
        stalled = 1;
        held = res_data;
      end
      if (res_valid && res_ready) begin
        if (got < expn) chk(res_data == expect_at(got), "R3 R4 result value", res_data, expect_at(got));
        else chk(0, expn == 0 ? "R8 result in empty job" : "R5 extra result", 32'(got), 32'(expn));
        got++;
        if (got == expn) prev_final = 1;
      end
      if (done != exp_done)
        chk(0, expn == 0 ? "R8 done timing" : "R7 done timing", 32'(done), 32'(exp_done));
      if (exp_done) begin
        chk(done && !res_valid, expn == 0 ? "R8 done pulse" : "R7 done pulse", {30'b0, done, res_valid}, 2);
        chk(got == expn, "R5 result count", 32'(got), 32'(expn));
        @(posedge clk);
        @(negedge clk);
        #5;
        chk(!done && !res_valid, "R7 done one cycle", {30'b0, done, res_valid}, 0);
        break;
      end
      @(posedge clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(!res_valid && !done && !rhs_ready, "R9 reset state", {29'b0, res_valid, done, rhs_ready}, 0);
    rst = 1'b0;
    for (int md = 0; md < 2; md++) begin
      mode = md;
      for (int a = 0; a <= 4; a++)
        for (int b = 0; b <= 4; b++)
          for (int c = 0; c <= 4; c++) begin
            n_c = a; p_c = b; m_c = c;
            for (int i = 0; i < 5; i++)
              for (int j = 0; j < 5; j++) begin
                mx[i][j] = (i == j && md == 1) ? 32'h7fffffff : $urandom;
                my[i][j] = (i + j == 4 && md == 1) ? 32'h80000000 : $urandom;
              end
            lhs_fin = 1'b0;
            fork
              drive_lhs();
              drive_rhs();
              receive();
            join
          end
    end
    summary();
    $finish;
  end
endmodule